// File: doc/BRIEF.md
# Dual-Mode Transmit Frame FIFO

This block is a byte-wide frame buffer placed between a DMA engine that writes outgoing frames and a MAC that reads them. The writer pushes bytes and tags the final byte of each frame. The reader sees a frame-ready indication, then pulls bytes one at a time. Each returned byte carries start-of-frame and end-of-frame tags.

The block decides when a buffered frame may begin to drain. In cut-through mode it releases a frame once enough bytes are held, or once the frame is complete. In store-and-forward mode it waits for the complete frame. The exception is a frame too large for the buffer, which it releases when the buffer is nearly full. Once a frame starts draining, it runs to its end marker.

A flush command empties the buffer over a fixed number of cycles and then clears itself. A reader that asks for a byte mid-frame while the buffer is empty causes an underflow. The underflow raises a sticky flag, and the block discards whatever remains of that frame.

Top module: `txq_frame_fifo`

## Requirements
- R1: With `mode_saf`=0, a frame is released (`frame_rdy` goes to 1) once the stored byte count reaches (`thr_sel`+1)×64, i.e. 64/128/192/256 for codes 0/1/2/3. Below that count, without a stored end marker, `frame_rdy` stays 0.
- R2: With `mode_saf`=0, a frame whose end-of-frame byte has been written is released even when the count is below the threshold.
- R3: With `mode_saf`=1, a frame is not released until its end-of-frame byte is stored, even when the count is far above every cut-through threshold.
- R4: With `mode_saf`=1, a frame with no end marker yet is released once the count reaches depth minus 8 (504 at default depth). At 503 bytes it is not released.
- R5: While released, each cycle with `rd_req`=1 and data present pops one byte, which appears with `rd_valid`=1 on the next cycle. Bytes arrive in write order, with `rd_sof`=1 on the first byte and `rd_eof`=1 on the byte written with `wr_last`. Draining continues after the count falls below the release level.
- R6: When no frame is released, `rd_req` is ignored: no byte is popped and `rd_valid` stays 0.
- R7: A `flush_req` pulse sets `flush_busy` for exactly 4 cycles. During those cycles `wr_ready`=0. Afterwards all stored data is gone, `flush_busy` returns to 0 by itself, and `frame_rdy`=0.
- R8: `rd_req`=1 while released with the buffer empty sets `urun_flag`. The flag holds until `urun_clr`=1.
- R9: After an underflow, the remaining bytes of that frame, up to and including its end-of-frame byte, are discarded and never presented. The next frame starts cleanly with `rd_sof`=1.
- R10: When 512 bytes are stored, `wr_ready`=0 and writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_saf | input | 1 | 1 = store-and-forward release, 0 = cut-through |
| thr_sel | input | 2 | Cut-through threshold code |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Byte is the last of its frame |
| wr_ready | output | 1 | Write accepted this cycle when high |
| rd_req | input | 1 | Reader requests a byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| rd_sof | output | 1 | Read byte is first of frame |
| rd_eof | output | 1 | Read byte is last of frame |
| frame_rdy | output | 1 | A frame is released for draining |
| flush_req | input | 1 | Flush command pulse |
| flush_busy | output | 1 | Flush in progress |
| urun_clr | input | 1 | Write-1 clear of underflow flag |
| urun_flag | output | 1 | Sticky underflow flag |

## Verification
A bad pointer or end-marker count shows up at the read port within one cycle of the affected pop. The byte comes out wrong or out of order, or the end tag lands on the wrong byte, and the scoreboard catches it on that byte. A wrong release decision shows on `frame_rdy` two cycles after the triggering write, so each threshold is probed one byte below and at its level. Drop and flush faults leak stale bytes into the next frame and are caught on its first byte.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_DROP  = 2'd2
  } txq_st_e;

  function automatic int unsigned thr_bytes(input logic [1:0] sel, input int unsigned unit);
    return (32'(sel) + 32'd1) * unit;
  endfunction

endpackage

// File: rtl/txq_ram.sv
module txq_ram #(
  parameter int W      = 8,
  parameter int AW     = 9,
  parameter bit REG_RD = 1'b1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [0:N-1];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  generate
    if (REG_RD) begin : g_sync
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (re) q_r <= mem[ra];
      end
      assign rd = q_r;
    end else begin : g_async
      assign rd = re ? mem[ra] : '0;
    end
  endgenerate
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          push_last,
  input  logic          pop,
  input  logic          pop_last,
  output logic [AW-1:0] wa,
  output logic [AW-1:0] ra,
  output logic [AW:0]   cnt,
  output logic [AW:0]   eof_cnt,
  output logic          full
);
  localparam logic [AW:0] CAP = (AW+1)'(1 << AW);

  logic [AW:0] wp, rp;

  assign wa   = wp[AW-1:0];
  assign ra   = rp[AW-1:0];
  assign cnt  = wp - rp;
  assign full = (cnt == CAP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp      <= '0;
      rp      <= '0;
      eof_cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push && push_last, pop && pop_last})
        2'b10:   eof_cnt <= eof_cnt + 1'b1;
        2'b01:   eof_cnt <= eof_cnt - 1'b1;
        default: eof_cnt <= eof_cnt;
      endcase
    end
  end

  // R5: the controller never pops an empty buffer
  a_r5_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));

  // R10: occupancy never exceeds capacity
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CAP) && (eof_cnt <= cnt));
endmodule

// File: rtl/txq_flush.sv
module txq_flush #(
  parameter int FLUSH_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_req,
  output logic busy,
  output logic clr
);
  localparam int CW = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1;

  logic [CW-1:0] left;

  assign clr = busy && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end else if (flush_req) begin
      busy <= 1'b1;
      left <= CW'(FLUSH_CYC - 1);
    end
  end

  // R7: the busy window ends by itself
  a_r7_self_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !busy);
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int AW        = 9,
  parameter int THR_UNIT  = 64,
  parameter int AF_MARGIN = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        busy,
  input  logic        mode_saf,
  input  logic [1:0]  thr_sel,
  input  logic        rd_req,
  input  logic [AW:0] cnt,
  input  logic [AW:0] eof_cnt,
  input  logic        head_last,
  input  logic        urun_clr,
  output logic        pop,
  output logic        frame_rdy,
  output logic        rd_valid,
  output logic        rd_sof,
  output logic        rd_eof,
  output logic        urun_flag
);
  localparam logic [AW:0] AF_LVL = (AW+1)'((1 << AW) - AF_MARGIN);

  txq_st_e        st;
  logic           first;
  logic           cnt_nz, have_eof, go, starve, pop_out;
  logic [AW+1:0]  thr_w;

  assign cnt_nz   = (cnt != '0);
  assign have_eof = (eof_cnt != '0);
  assign thr_w    = (AW+2)'(thr_bytes(thr_sel, THR_UNIT));

  always_comb begin
    if (mode_saf) go = have_eof || (cnt >= AF_LVL);
    else          go = have_eof || ({1'b0, cnt} >= thr_w);
  end

  assign pop_out = !busy && (st == ST_DRAIN) && rd_req && cnt_nz;
  assign starve  = !busy && (st == ST_DRAIN) && rd_req && !cnt_nz;
  assign pop     = pop_out || (!busy && (st == ST_DROP) && cnt_nz);
  assign frame_rdy = (st == ST_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      first     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_sof    <= 1'b0;
      rd_eof    <= 1'b0;
      urun_flag <= 1'b0;
    end else begin
      rd_valid <= pop_out;
      rd_sof   <= pop_out && first;
      rd_eof   <= pop_out && head_last;
      if (starve)        urun_flag <= 1'b1;
      else if (urun_clr) urun_flag <= 1'b0;

      if (clr) begin
        st    <= ST_IDLE;
        first <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (!busy && go) begin
            st    <= ST_DRAIN;
            first <= 1'b1;
          end
          ST_DRAIN: begin
            if (pop_out) begin
              first <= 1'b0;
              if (head_last) st <= ST_IDLE;
            end else if (starve) begin
              st <= ST_DROP;
            end
          end
          ST_DROP: if (pop && head_last) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: a stored end marker releases the head frame in cut-through mode
  a_r2_eof_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) && !mode_saf && have_eof && !busy && !clr |=> (st == ST_DRAIN));

  // R3: store-and-forward holds an incomplete frame below the almost-full level
  a_r3_saf_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) && mode_saf && !have_eof && (cnt < AF_LVL) |=> (st != ST_DRAIN));

  // R8: underflow flag is sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    urun_flag && !urun_clr |=> urun_flag);

  // R9: a starved frame is never presented again
  a_r9_drop_silent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DROP) |=> !rd_valid);
endmodule

// File: rtl/txq_frame_fifo.sv
module txq_frame_fifo #(
  parameter int DEPTH     = 512,
  parameter int THR_UNIT  = 64,
  parameter int AF_MARGIN = 8,
  parameter int FLUSH_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_saf,
  input  logic [1:0] thr_sel,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  output logic       wr_ready,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_sof,
  output logic       rd_eof,
  output logic       frame_rdy,
  input  logic       flush_req,
  output logic       flush_busy,
  input  logic       urun_clr,
  output logic       urun_flag
);
  localparam int AW = $clog2(DEPTH);

  logic          push, pop, full, clr, head_last;
  logic [AW-1:0] wa, ra;
  logic [AW:0]   cnt, eof_cnt;
  logic [0:0]    flag_q;

  assign wr_ready  = !full && !flush_busy;
  assign push      = wr_valid && wr_ready;
  assign head_last = flag_q[0];

  txq_flush #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
    .clk(clk), .rst(rst), .flush_req(flush_req), .busy(flush_busy), .clr(clr)
  );

  txq_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .clr(clr),
    .push(push), .push_last(wr_last), .pop(pop), .pop_last(head_last),
    .wa(wa), .ra(ra), .cnt(cnt), .eof_cnt(eof_cnt), .full(full)
  );

  txq_ram #(.W(8), .AW(AW), .REG_RD(1'b1)) u_data (
    .clk(clk), .we(push), .wa(wa), .wd(wr_data),
    .re(pop), .ra(ra), .rd(rd_data)
  );

  txq_ram #(.W(1), .AW(AW), .REG_RD(1'b0)) u_flag (
    .clk(clk), .we(push), .wa(wa), .wd(wr_last),
    .re(1'b1), .ra(ra), .rd(flag_q)
  );

  txq_ctrl #(.AW(AW), .THR_UNIT(THR_UNIT), .AF_MARGIN(AF_MARGIN)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .busy(flush_busy),
    .mode_saf(mode_saf), .thr_sel(thr_sel), .rd_req(rd_req),
    .cnt(cnt), .eof_cnt(eof_cnt), .head_last(head_last), .urun_clr(urun_clr),
    .pop(pop), .frame_rdy(frame_rdy), .rd_valid(rd_valid),
    .rd_sof(rd_sof), .rd_eof(rd_eof), .urun_flag(urun_flag)
  );

  // R6: no byte appears unless a frame was released
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !frame_rdy |=> !rd_valid);

  // R7: when the flush window closes the buffer is empty
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_busy) |-> (cnt == '0) && (eof_cnt == '0) && !frame_rdy);

  // R10: a full buffer refuses the writer
  a_r10_full_stall: assert property (@(posedge clk) disable iff (rst)
    full && !pop |=> !$changed(cnt) || clr);
endmodule

// File: tb/sim_txq_frame_fifo.sv
module sim_txq_frame_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_saf = 1'b0;
  logic [1:0] thr_sel = 2'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_last = 1'b0;
  logic       wr_ready;
  logic       rd_req = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_sof, rd_eof, frame_rdy;
  logic       flush_req = 1'b0;
  logic       flush_busy;
  logic       urun_clr = 1'b0;
  logic       urun_flag;

  int n_run = 0;
  int n_bad = 0;
  int n_rx  = 0;
  bit got_eof = 1'b0;
  bit first_b = 1'b1;
  logic [9:0] sb[$];

  always #4 clk = ~clk;

  txq_frame_fifo u0 (
    .clk(clk), .rst(rst), .mode_saf(mode_saf), .thr_sel(thr_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_sof(rd_sof), .rd_eof(rd_eof), .frame_rdy(frame_rdy),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .urun_clr(urun_clr), .urun_flag(urun_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  // monitor / scoreboard: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rd_valid) begin
        n_rx++;
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected byte", int'(rd_data), -1);
        end else begin
          logic [9:0] e;
          e = sb.pop_front();
          chk({rd_sof, rd_eof, rd_data} == e, "R5", "byte/sof/eof",
              int'({rd_sof, rd_eof, rd_data}), int'(e));
        end
        if (rd_eof) got_eof = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  task automatic put(input logic [7:0] d, input bit last, input bit exp);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    wr_last  = last;
    while (!wr_ready) @(negedge clk);
    if (exp) sb.push_back({first_b, last, d});
    first_b = last;
    @(posedge clk);
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic put_run(input int n, input logic [7:0] seed, input bit end_last, input bit exp);
    for (int i = 0; i < n; i++)
      put(seed + 8'(i), end_last && (i == n - 1), exp);
    wr_idle();
  endtask

  task automatic rd_frame();
    got_eof = 1'b0;
    @(negedge clk);
    rd_req = 1'b1;
    do @(negedge clk); while (!got_eof);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int nb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R10", "reset wr_ready", wr_ready, 1);
    chk(frame_rdy == 1'b0, "R1", "reset frame_rdy", frame_rdy, 0);
    chk(flush_busy == 1'b0, "R7", "reset flush_busy", flush_busy, 0);
    chk(urun_flag == 1'b0, "R8", "reset urun_flag", urun_flag, 0);

    // R1: cut-through threshold 64, then continued drain below it (R5)
    put_run(63, 8'h10, 1'b0, 1'b1);
    idle(4);
    chk(frame_rdy == 1'b0, "R1", "63 bytes thr64", frame_rdy, 0);
    put_run(1, 8'h4F, 1'b0, 1'b1);
    idle(2);
    chk(frame_rdy == 1'b1, "R1", "64 bytes thr64", frame_rdy, 1);
    put_run(36, 8'h50, 1'b1, 1'b1);
    rd_frame();
    idle(3);
    chk(sb.size() == 0, "R5", "ct frame drained", sb.size(), 0);
    chk(frame_rdy == 1'b0, "R5", "idle after eof", frame_rdy, 0);

    // R1: code 2 -> 192
    thr_sel = 2'd2;
    put_run(191, 8'h01, 1'b0, 1'b1);
    idle(4);
    chk(frame_rdy == 1'b0, "R1", "191 bytes thr192", frame_rdy, 0);
    put_run(1, 8'hC0, 1'b0, 1'b1);
    idle(2);
    chk(frame_rdy == 1'b1, "R1", "192 bytes thr192", frame_rdy, 1);
    put_run(2, 8'hD0, 1'b1, 1'b1);
    rd_frame();
    idle(3);
    chk(sb.size() == 0, "R1", "thr192 frame drained", sb.size(), 0);

    // R6 and R2: short frame under threshold 256
    thr_sel = 2'd3;
    put_run(10, 8'hA0, 1'b0, 1'b1);
    nb = n_rx;
    @(negedge clk); rd_req = 1'b1;
    idle(10);
    rd_req = 1'b0;
    idle(2);
    chk(n_rx == nb, "R6", "rd_req ignored bytes", n_rx - nb, 0);
    chk(frame_rdy == 1'b0, "R6", "not released", frame_rdy, 0);
    put_run(1, 8'hAA, 1'b1, 1'b1);
    idle(2);
    chk(frame_rdy == 1'b1, "R2", "eof release", frame_rdy, 1);
    rd_frame();
    idle(3);
    chk(sb.size() == 0, "R2", "short frame drained", sb.size(), 0);

    // R3: store-and-forward waits for the end marker
    mode_saf = 1'b1;
    thr_sel  = 2'd0;
    put_run(300, 8'h33, 1'b0, 1'b1);
    idle(4);
    chk(frame_rdy == 1'b0, "R3", "300 bytes no eof", frame_rdy, 0);
    put_run(1, 8'h77, 1'b1, 1'b1);
    idle(2);
    chk(frame_rdy == 1'b1, "R3", "eof stored", frame_rdy, 1);
    rd_frame();
    idle(3);
    chk(sb.size() == 0, "R3", "saf frame drained", sb.size(), 0);

    // R4: oversize frame released at depth-8
    put_run(503, 8'h05, 1'b0, 1'b1);
    idle(4);
    chk(frame_rdy == 1'b0, "R4", "503 bytes", frame_rdy, 0);
    put_run(1, 8'hF0, 1'b0, 1'b1);
    idle(2);
    chk(frame_rdy == 1'b1, "R4", "504 bytes", frame_rdy, 1);
    fork
      put_run(96, 8'h60, 1'b1, 1'b1);
      rd_frame();
    join
    idle(3);
    chk(sb.size() == 0, "R4", "oversize drained", sb.size(), 0);

    // R10: full buffer blocks writes; blocked writes leave no trace
    put_run(512, 8'h21, 1'b1, 1'b1);
    idle(1);
    chk(wr_ready == 1'b0, "R10", "wr_ready when full", wr_ready, 0);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
    idle(3);
    wr_valid = 1'b0; wr_last = 1'b0;
    rd_frame();
    idle(5);
    chk(sb.size() == 0, "R10", "full frame drained", sb.size(), 0);
    chk(frame_rdy == 1'b0, "R10", "blocked writes dropped", frame_rdy, 0);

    // R7: flush
    put_run(100, 8'h90, 1'b0, 1'b0);
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    chk(wr_ready == 1'b0, "R7", "writes blocked in flush", wr_ready, 0);
    nb = 0;
    while (flush_busy) begin nb++; @(negedge clk); end
    chk(nb == 4, "R7", "flush busy cycles", nb, 4);
    chk(wr_ready == 1'b1, "R7", "wr_ready after flush", wr_ready, 1);
    chk(frame_rdy == 1'b0, "R7", "frame_rdy after flush", frame_rdy, 0);
    first_b = 1'b1;
    put_run(5, 8'hB0, 1'b1, 1'b1);
    rd_frame();
    idle(3);
    chk(sb.size() == 0, "R7", "post-flush frame clean", sb.size(), 0);

    // R8, R9: underflow, sticky flag, drop of the remainder
    mode_saf = 1'b0;
    thr_sel  = 2'd0;
    put_run(70, 8'h00, 1'b0, 1'b1);
    @(negedge clk); rd_req = 1'b1;
    idle(80);
    rd_req = 1'b0;
    idle(1);
    chk(sb.size() == 0, "R8", "bytes before starve", sb.size(), 0);
    chk(urun_flag == 1'b1, "R8", "underflow flag set", urun_flag, 1);
    nb = n_rx;
    put_run(5, 8'hE0, 1'b1, 1'b0);
    idle(10);
    chk(n_rx == nb, "R9", "remainder not shown", n_rx - nb, 0);
    chk(frame_rdy == 1'b0, "R9", "remainder dropped", frame_rdy, 0);
    chk(urun_flag == 1'b1, "R8", "flag sticky", urun_flag, 1);
    put_run(3, 8'hC5, 1'b1, 1'b1);
    rd_frame();
    idle(3);
    chk(sb.size() == 0, "R9", "next frame clean", sb.size(), 0);
    @(negedge clk); urun_clr = 1'b1;
    @(negedge clk); urun_clr = 1'b0;
    chk(urun_flag == 1'b0, "R8", "flag cleared", urun_flag, 0);

    idle(5);
    report();
  end
endmodule